// File: doc/BRIEF.md
# Direct-Mapped Data Cache With I/O Bypass

This block sits between a processor load/store port and the request port of a cache controller. It holds 4 KB of data in a direct-mapped array of 128 lines of eight 32-bit words. A cacheable load whose line is present returns its word in the same cycle. A cacheable load whose line is absent fetches the whole line from the controller and then completes from the array. Stores are write-through without allocation: every cacheable store goes to the controller, and it also updates the array only when the line is already present.

Addresses whose top four bits are 4'h8 belong to devices. Such accesses never look at, fill or update the arrays. Each one is sent to the controller as a single word read or write, and the reply completes the access. The processor holds its request stable until `cpu_ack` is seen, and it is stalled for every access that needs the controller.

Top module: `dcache_bypass`

## Requirements
- R1: After reset every line is invalid, `ctl_req` and `cpu_ack` are low, and the first cacheable load to any address misses.
- R2: A cacheable load whose index holds a valid line with a matching tag (tag = addr[31:12], index = addr[11:5], word = addr[4:2]) asserts `cpu_ack` in the cycle it is presented, with the stored word on `cpu_rdata`, and raises no controller request.
- R3: A cacheable load miss raises `ctl_req` with `ctl_kind` = 0 (line fill) and `ctl_addr` = the address with bits [4:0] cleared. It accepts eight `ctl_rvalid` beats carrying words 0 to 7 in order, and it acknowledges the load from the array in the cycle after `ctl_done`.
- R4: A cacheable store raises `ctl_req` with `ctl_kind` = 1 (memory write), the full address and the store data, and it is acknowledged in the `ctl_done` cycle. If the line is present, the word is also updated, and a later load hits with the new value.
- R5: A cacheable store to an absent line does not allocate it, so a later load to that address still misses.
- R6: An access with addr[31:28] = 4'h8 raises `ctl_req` with `ctl_kind` = 2 (device read) or 3 (device write). A device read returns `ctl_rdata` in the `ctl_done` cycle. Device accesses never allocate or change any line, and repeating a device read issues a new request each time.
- R7: `cpu_ack` stays low while a controller request is outstanding. `ctl_req` stays high from its issue through the `ctl_done` cycle and is low in the cycle after that.
- R8: Two cacheable addresses with the same index and different tags evict each other.
- R9: While `ctl_req` is high, `ctl_kind`, `ctl_addr` and `ctl_wdata` stay stable, and a line-fill address always has bits [4:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| ctl_req | output | 1 | Controller request, level until done |
| ctl_kind | output | 2 | 0 fill, 1 memory write, 2 device read, 3 device write |
| ctl_addr | output | 32 | Request address |
| ctl_wdata | output | 32 | Write data for kinds 1 and 3 |
| ctl_rvalid | input | 1 | One fill word on ctl_rdata |
| ctl_rdata | input | 32 | Fill word or device read data |
| ctl_done | input | 1 | Request finished |

## Verification
A wrong valid bit or tag shows up directly at the ports. A line that should be present produces an unexpected fill request in the same cycle as the load. A line that should be absent gives an immediate acknowledge with stale data. A corrupted data word, for example from a device write or from a store that allocated its line, appears on `cpu_rdata` at the next hit to that word, which can be many accesses later. The sequence is therefore built so that each store or device write is followed soon by a load to the same index. A fill that places beats at the wrong offsets is seen on the first load to any word other than the one that missed.

// File: rtl/dcache_bypass_pkg.sv
package dcache_bypass_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        KIND_FILL  = 2'd0,
        KIND_MEMWR = 2'd1,
        KIND_IORD  = 2'd2,
        KIND_IOWR  = 2'd3
    } ctl_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_DEV
    } dc_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        ctl_kind_e         kind;
        logic              was_hit;
    } pend_req_t;

    function automatic logic in_dev_region(input logic [ADDR_W-1:0] a,
                                           input logic [3:0] nib);
        return a[ADDR_W-1 -: 4] == nib;
    endfunction

endpackage

// File: rtl/dcache_bypass_split.sv
module dcache_bypass_split #(
    parameter int IDX_W = 7,
    parameter int OFF_W = 3,
    localparam int WA_W  = dcache_bypass_pkg::ADDR_W - 2,
    localparam int TAG_W = WA_W - IDX_W - OFF_W
) (
    input  logic [WA_W-1:0]  word_addr,
    output logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] off,
    output logic [TAG_W-1:0] tag
);
    assign off = word_addr[OFF_W-1:0];
    assign idx = word_addr[OFF_W +: IDX_W];
    assign tag = word_addr[WA_W-1 -: TAG_W];
endmodule

// File: rtl/dcache_bypass_tags.sv
module dcache_bypass_tags #(
    parameter int NUM_LINES = 128,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/dcache_bypass_data.sv
module dcache_bypass_data #(
    parameter int NUM_LINES = 128,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int OFF_W = $clog2(LINE_WORDS),
    localparam int DEPTH = NUM_LINES * LINE_WORDS,
    localparam int DW = dcache_bypass_pkg::DATA_W
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data
);
    logic [DW-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    assign rd_data = word_q[{rd_idx, rd_off}];
endmodule

// File: rtl/dcache_bypass_ctrl.sv
module dcache_bypass_ctrl
    import dcache_bypass_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int LINE_WORDS = 8,
    parameter logic [3:0] DEV_NIBBLE = 4'h8,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int OFF_W = $clog2(LINE_WORDS),
    localparam int TAG_W = ADDR_W - 2 - IDX_W - OFF_W,
    localparam int LOW_W = OFF_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ctl_req,
    output ctl_kind_e         ctl_kind,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_rvalid,
    input  logic [DATA_W-1:0] ctl_rdata,
    input  logic              ctl_done,
    output logic              tw_en,
    output logic [IDX_W-1:0]  tw_idx,
    output logic [TAG_W-1:0]  tw_tag,
    output logic              tw_valid,
    output logic              dw_en,
    output logic [IDX_W-1:0]  dw_idx,
    output logic [OFF_W-1:0]  dw_off,
    output logic [DATA_W-1:0] dw_data
);
    dc_state_e        state_q, state_d;
    pend_req_t        pend_q, pend_d;
    logic [OFF_W-1:0] beat_q;
    logic             dev_acc;
    logic             launch;

    logic [IDX_W-1:0] pend_idx;
    logic [OFF_W-1:0] pend_off;
    logic [TAG_W-1:0] pend_tag;
    logic [IDX_W-1:0] cpu_idx;

    assign dev_acc  = in_dev_region(cpu_addr, DEV_NIBBLE);
    assign pend_idx = pend_q.addr[LOW_W +: IDX_W];
    assign pend_off = pend_q.addr[2 +: OFF_W];
    assign pend_tag = pend_q.addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx  = cpu_addr[LOW_W +: IDX_W];

    // Next state and the request that a new access opens
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        launch  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    pend_d.addr    = cpu_addr;
                    pend_d.wdata   = cpu_wdata;
                    pend_d.was_hit = hit;
                    if (dev_acc) begin
                        launch      = 1'b1;
                        state_d     = ST_DEV;
                        pend_d.kind = cpu_we ? KIND_IOWR : KIND_IORD;
                    end else if (cpu_we) begin
                        launch      = 1'b1;
                        state_d     = ST_WRITE;
                        pend_d.kind = KIND_MEMWR;
                    end else if (!hit) begin
                        launch      = 1'b1;
                        state_d     = ST_FILL;
                        pend_d.kind = KIND_FILL;
                        pend_d.addr = {cpu_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
                    end
                end
            end
            ST_FILL, ST_WRITE, ST_DEV: begin
                if (ctl_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                pend_q <= pend_d;
                beat_q <= '0;
            end else if (state_q == ST_FILL && ctl_rvalid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Processor side
    always_comb begin
        cpu_ack   = 1'b0;
        cpu_rdata = arr_rdata;
        case (state_q)
            ST_IDLE:  cpu_ack = cpu_req && !dev_acc && !cpu_we && hit;
            ST_WRITE: cpu_ack = ctl_done;
            ST_DEV: begin
                cpu_ack   = ctl_done;
                cpu_rdata = ctl_rdata;
            end
            default: cpu_ack = 1'b0;
        endcase
    end

    // Controller side
    assign ctl_req   = (state_q != ST_IDLE);
    assign ctl_kind  = pend_q.kind;
    assign ctl_addr  = pend_q.addr;
    assign ctl_wdata = pend_q.wdata;

    // Tag array updates: drop the line when its fill starts, mark it at the end
    always_comb begin
        tw_en    = 1'b0;
        tw_idx   = pend_idx;
        tw_tag   = pend_tag;
        tw_valid = 1'b0;
        if (launch && state_d == ST_FILL) begin
            tw_en  = 1'b1;
            tw_idx = cpu_idx;
        end else if (state_q == ST_FILL && ctl_done) begin
            tw_en    = 1'b1;
            tw_valid = 1'b1;
        end
    end

    // Data array updates: fill beats, or a store to a present line
    always_comb begin
        dw_en   = 1'b0;
        dw_idx  = pend_idx;
        dw_off  = beat_q;
        dw_data = ctl_rdata;
        if (state_q == ST_FILL && ctl_rvalid) begin
            dw_en = 1'b1;
        end else if (state_q == ST_WRITE && ctl_done && pend_q.was_hit) begin
            dw_en   = 1'b1;
            dw_off  = pend_off;
            dw_data = pend_q.wdata;
        end
    end
endmodule

// File: rtl/dcache_bypass.sv
module dcache_bypass
    import dcache_bypass_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int LINE_WORDS = 8,
    parameter logic [3:0] DEV_NIBBLE = 4'h8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ack,
    output logic [31:0]       cpu_rdata,
    output logic              ctl_req,
    output logic [1:0]        ctl_kind,
    output logic [31:0]       ctl_addr,
    output logic [31:0]       ctl_wdata,
    input  logic              ctl_rvalid,
    input  logic [31:0]       ctl_rdata,
    input  logic              ctl_done
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int TAG_W = ADDR_W - 2 - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [OFF_W-1:0]  lk_off;
    logic [TAG_W-1:0]  lk_tag;
    logic [TAG_W-1:0]  st_tag;
    logic              st_valid;
    logic              hit;
    logic [DATA_W-1:0] arr_rdata;
    ctl_kind_e         kind_e;

    logic              tw_en, tw_valid, dw_en;
    logic [IDX_W-1:0]  tw_idx, dw_idx;
    logic [TAG_W-1:0]  tw_tag;
    logic [OFF_W-1:0]  dw_off;
    logic [DATA_W-1:0] dw_data;

    dcache_bypass_split #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .word_addr (cpu_addr[ADDR_W-1:2]),
        .idx       (lk_idx),
        .off       (lk_off),
        .tag       (lk_tag)
    );

    dcache_bypass_tags #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_tag   (st_tag),
        .rd_valid (st_valid),
        .wr_en    (tw_en),
        .wr_idx   (tw_idx),
        .wr_tag   (tw_tag),
        .wr_valid (tw_valid)
    );

    dcache_bypass_data #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS)) u_data (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_off  (lk_off),
        .rd_data (arr_rdata),
        .wr_en   (dw_en),
        .wr_idx  (dw_idx),
        .wr_off  (dw_off),
        .wr_data (dw_data)
    );

    assign hit = st_valid && (st_tag == lk_tag);

    dcache_bypass_ctrl #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .DEV_NIBBLE (DEV_NIBBLE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .hit        (hit),
        .arr_rdata  (arr_rdata),
        .cpu_ack    (cpu_ack),
        .cpu_rdata  (cpu_rdata),
        .ctl_req    (ctl_req),
        .ctl_kind   (kind_e),
        .ctl_addr   (ctl_addr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rvalid (ctl_rvalid),
        .ctl_rdata  (ctl_rdata),
        .ctl_done   (ctl_done),
        .tw_en      (tw_en),
        .tw_idx     (tw_idx),
        .tw_tag     (tw_tag),
        .tw_valid   (tw_valid),
        .dw_en      (dw_en),
        .dw_idx     (dw_idx),
        .dw_off     (dw_off),
        .dw_data    (dw_data)
    );

    assign ctl_kind = kind_e;
endmodule

// File: rtl/dcache_bypass_chk.sv
module dcache_bypass_chk #(
    parameter logic [3:0] DEV_NIBBLE = 4'h8
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic        cpu_ack,
    input logic        ctl_req,
    input logic [1:0]  ctl_kind,
    input logic [31:0] ctl_addr,
    input logic [31:0] ctl_wdata,
    input logic        ctl_done
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ctl_req && !cpu_ack)); // R1

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> cpu_req); // R7

    AST_STORE_ACK_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && cpu_we) |-> (ctl_req && ctl_done)); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && !ctl_done) |=> ctl_req); // R7

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && ctl_done) |=> !ctl_req); // R7

    AST_NO_ACK_WHILE_FILL: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && ctl_kind == 2'd0) |-> !cpu_ack); // R3

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && !ctl_done) |=> ($stable(ctl_kind) && $stable(ctl_addr)
                                     && $stable(ctl_wdata))); // R9

    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && ctl_kind == 2'd0) |-> (ctl_addr[4:0] == 5'd0)); // R9

    AST_DEV_KIND: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && ctl_addr[31:28] == DEV_NIBBLE) |-> ctl_kind[1]); // R6
endmodule

bind dcache_bypass dcache_bypass_chk #(.DEV_NIBBLE(DEV_NIBBLE)) u_chk (.*);

// File: tb/dcache_bypass_test.sv
module dcache_bypass_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        ctl_req;
    logic [1:0]  ctl_kind;
    logic [31:0] ctl_addr;
    logic [31:0] ctl_wdata;
    logic        ctl_rvalid = 1'b0;
    logic [31:0] ctl_rdata = '0;
    logic        ctl_done = 1'b0;

    always #5 clk = ~clk;

    dcache_bypass uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .ctl_req(ctl_req), .ctl_kind(ctl_kind), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata), .ctl_done(ctl_done)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Behavioural reference state
    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] dev_m [logic [31:0]];
    bit          ref_valid [int];
    int          ref_tag [int];

    // What the controller model saw
    int          n_issue = 0;
    logic [1:0]  seen_kind;
    logic [31:0] seen_addr;
    logic [31:0] seen_wdata;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        if (mem_m.exists(w)) return mem_m[w];
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] dev_rd(input logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        if (dev_m.exists(w)) return dev_m[w];
        return w ^ 32'hC0DE_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Controller model: answers at negedges after a short, varying delay
    initial begin
        forever begin
            @(negedge clk);
            ctl_done   = 1'b0;
            ctl_rvalid = 1'b0;
            if (ctl_req) begin
                seen_kind  = ctl_kind;
                seen_addr  = ctl_addr;
                seen_wdata = ctl_wdata;
                n_issue++;
                repeat (1 + (n_issue % 3)) @(negedge clk);
                if (seen_kind == 2'd0) begin
                    for (int b = 0; b < 8; b++) begin
                        if (b > 0) @(negedge clk);
                        ctl_rvalid = 1'b1;
                        ctl_rdata  = mem_rd(seen_addr + 32'(4 * b));
                        ctl_done   = (b == 7);
                    end
                end else begin
                    ctl_rdata = (seen_kind == 2'd2) ? dev_rd(seen_addr) : 32'h0BAD_0BAD;
                    ctl_done  = 1'b1;
                end
            end
        end
    end

    // One processor access, checked against the reference model
    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          input string req);
        bit          dev  = (a[31:28] == 4'h8);
        int          idx  = int'(a[11:5]);
        int          tag  = int'(a[31:12]);
        bit          hit  = !dev && !we && ref_valid.exists(idx) && ref_valid[idx]
                            && ref_tag[idx] == tag;
        logic [1:0]  ekind;
        logic [31:0] eaddr;
        logic [31:0] edata;
        int          start = n_issue;
        int          cyc = 0;
        bit          acked = 0;

        if (dev) ekind = we ? 2'd3 : 2'd2;
        else if (we) ekind = 2'd1;
        else ekind = 2'd0;
        eaddr = (!dev && !we) ? {a[31:5], 5'd0} : a;
        edata = dev ? dev_rd(a) : mem_rd(a);

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        while (cyc < 200) begin
            #4;
            if (cpu_ack) begin acked = 1; break; end
            cyc++;
            @(negedge clk);
        end
        chk(acked, req, "ack seen", 32'(acked), 32'd1);
        if (!we) chk(cpu_rdata == edata, req, "load data", cpu_rdata, edata);
        if (hit) begin
            chk(cyc == 0, req, "hit latency", 32'(cyc), 32'd0);
            chk(n_issue == start, req, "no request on hit", 32'(n_issue - start), 32'd0);
        end else begin
            chk(cyc > 0, req, "stall before ack", 32'(cyc), 32'd1);
            chk(n_issue - start == 1, req, "one request", 32'(n_issue - start), 32'd1);
            chk(seen_kind == ekind, req, "request kind", 32'(seen_kind), 32'(ekind));
            chk(seen_addr == eaddr, req, "request addr", seen_addr, eaddr);
            if (we) chk(seen_wdata == wd, req, "request data", seen_wdata, wd);
        end
        @(negedge clk);
        cpu_req = 1'b0;
        if (dev && we) dev_m[{a[31:2], 2'b00}] = wd;
        else if (we) mem_m[{a[31:2], 2'b00}] = wd;
        else if (!dev) begin
            ref_valid[idx] = 1'b1;
            ref_tag[idx]   = tag;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #4;
        chk(!ctl_req, "R1", "ctl_req after reset", 32'(ctl_req), 32'd0);
        chk(!cpu_ack, "R1", "cpu_ack after reset", 32'(cpu_ack), 32'd0);

        access(0, 32'h0000_0104, 0, "R1");            // cold miss
        access(0, 32'h0000_0100, 0, "R2");            // hit, word 0
        access(0, 32'h0000_011C, 0, "R2");            // hit, last word (R3 beat order)
        access(0, 32'h0000_0110, 0, "R3");
        access(1, 32'h0000_0108, 32'hDEAD_BEEF, "R4"); // write hit
        access(0, 32'h0000_0108, 0, "R4");            // hit with new value
        access(1, 32'h0000_2004, 32'h1234_5678, "R5"); // write miss
        access(0, 32'h0000_2004, 0, "R5");            // still misses
        access(0, 32'h0000_1100, 0, "R8");            // same index as 0x100, evicts
        access(0, 32'h0000_0108, 0, "R8");            // misses again, new value from memory
        access(1, 32'h8000_0108, 32'hFACE_0001, "R6"); // device write, same index
        access(0, 32'h0000_0108, 0, "R6");            // line unchanged
        access(0, 32'h8000_0108, 0, "R6");            // device read
        access(0, 32'h8000_0108, 0, "R6");            // repeats, no caching
        access(1, 32'h0000_0108, 32'h0000_0042, "R7");
        access(0, 32'h0000_0108, 0, "R7");

        for (int i = 0; i < 48; i++) begin
            logic [31:0] a = 32'(i * 36) & 32'h0000_0FFC;
            if (i % 4 == 3) a = a | 32'h0000_3000;
            access((i % 5) == 2, a, 32'(i) * 32'h0101_0101, "R2");
        end
        for (int i = 0; i < 8; i++) begin
            access(0, 32'h0000_0600 + 32'(4 * i), 0, "R3");
        end

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule